// File: doc/BRIEF.md
# Privilege Mode and Access Controller

This block sits between a CPU's memory port and the rest of the memory system. It tracks which of three execution modes the CPU is in: firmware, application or system call. It also decides, for every request, whether the request may go on to memory. It watches instruction fetch addresses, so the mode changes without any software write. The first fetch from outside ROM drops the CPU into application mode for good. A full-word store to a fixed trigger address raises an interrupt request. The fetch of the interrupt entry point then lifts the CPU into system call mode, and the CPU stays there until the return-from-interrupt indication.

Each request is classified by the top byte of its address. The ROM, the firmware RAM, the SPI window, the device-secret store and the trigger window are guarded. Every other region is passed through untouched. For a guarded region the block grants the request, refuses it, or marks the region as hidden. A hidden region is one the current mode must not even see: its writes are dropped and its reads return zero. A fetch refused by the execute rule is reported on a one-cycle violation output. Once execution has left ROM, the secret-store enable stays low until reset, so even system call mode cannot reach the device secret.

Top module: `priv_access_ctrl`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (firmware), `secret_en_o` is 1, `irq_vec_o` is zero and `violation_o` is 0.
- R2: Regions are decoded from address bits [31:24]. ROM is 0x00, firmware RAM is 0xd0, SPI is 0xc5, the secret store is 0xc2 and the trigger window is 0xe1. Any other value is an open region, where reads, writes and fetches are granted in every mode.
- R3: In firmware mode, a valid fetch whose region is not ROM moves `mode_o` to 2'b01 (application) from the next cycle.
- R4: A valid store (not a fetch) with all four write strobes to exactly 0xe100_0000 sets `irq_vec_o[31]` from the next cycle. A partial store, a read, or a store to any other trigger-window address changes nothing. Trigger-window requests are never granted, and no bit of `irq_vec_o` other than bit 31 is ever set.
- R5: In application mode with bit 31 pending, a fetch from 0x0000_0010 is granted. From the next cycle `mode_o` is 2'b10 (system call) and bit 31 is clear. Outside that case, a fetch of that address is an ordinary ROM fetch.
- R6: `irq_return_i` in system call mode moves the mode to application from the next cycle. In other modes it has no effect.
- R7: In firmware mode, ROM reads and fetches are granted. Firmware RAM, SPI and the secret store are readable and writable. Writes to ROM are never granted in any mode, and such a write is not marked hidden.
- R8: In system call mode, ROM, firmware RAM and SPI have the same rights as in firmware mode. The secret store is hidden.
- R9: In application mode, ROM reads are granted and ROM fetches are refused, except for the entry fetch of R5. Firmware RAM, SPI and the secret store are hidden.
- R10: `secret_en_o` stays high until the first fetch outside ROM. It is low from the following cycle until reset, whatever the mode.
- R11: A request to a hidden region has `grant_o` low and `hidden_o` high in the same cycle. If it is a read or a fetch, `rdata_o` is zero in the next cycle. Otherwise `rdata_o` equals `mem_rdata_i`.
- R12: A fetch from a region without execute right is not granted. Such regions are firmware RAM, SPI, the secret store, the trigger window, ROM in application mode, and any hidden region. `violation_o` is high in exactly the next cycle, for one cycle per refused fetch.
- R13: `mode_o` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU request valid |
| req_addr_i | input | 32 | CPU request address |
| req_wstrb_i | input | 4 | Byte write strobes; zero means read |
| req_fetch_i | input | 1 | Request is an instruction fetch |
| irq_return_i | input | 1 | CPU is leaving its interrupt handler |
| mem_rdata_i | input | 32 | Read data returned by memory, one cycle after the request |
| mode_o | output | 2 | Current mode: 00 firmware, 01 application, 10 system call |
| grant_o | output | 1 | Request may be forwarded to memory |
| hidden_o | output | 1 | Request targets a region invisible in this mode |
| violation_o | output | 1 | Previous cycle held a refused fetch |
| rdata_o | output | 32 | Read data to CPU, zero for hidden reads |
| irq_vec_o | output | 32 | Interrupt request vector; only bit 31 is used |
| secret_en_o | output | 1 | Secret store may be accessed |

## Verification
`grant_o` and `hidden_o` are combinational and belong to the request presented in the same cycle. `mode_o`, `secret_en_o`, `irq_vec_o`, `violation_o` and the zeroing of `rdata_o` change only at the rising edge after the request that caused them. The bench drives each request at the falling edge and compares every output 2 ns later against a behavioural model. It advances that model only at the following rising edge, so same-cycle results and one-cycle-late results are each checked in the cycle they are due. The sequences walk all three modes, including a trigger raised in system call mode that must not cause an entry until application mode resumes.

// File: rtl/priv_access_pkg.sv
package priv_access_pkg;

   // Execution modes; the encoding is visible on mode_o.
   typedef enum logic [1:0] {
      MODE_FW  = 2'b00,
      MODE_APP = 2'b01,
      MODE_SYS = 2'b10
   } mode_e;

   // Guarded regions occupy the first codes, in decoder table order.
   typedef enum logic [2:0] {
      RG_ROM    = 3'd0,
      RG_FWRAM  = 3'd1,
      RG_SPI    = 3'd2,
      RG_SECRET = 3'd3,
      RG_TRIG   = 3'd4,
      RG_OPEN   = 3'd5
   } region_e;

   localparam int unsigned NUM_GUARDED = 5;

   typedef struct packed {
      logic vis;
      logic rd;
      logic wr;
      logic ex;
   } perm_t;

endpackage

// File: rtl/pa_region_decode.sv
module pa_region_decode
   import priv_access_pkg::*;
#(
   parameter int unsigned             ADDR_W      = 32,
   parameter int unsigned             REGION_BITS = 8,
   parameter logic [REGION_BITS-1:0]  ROM_BASE    = 'h00,
   parameter logic [REGION_BITS-1:0]  FWRAM_BASE  = 'hd0,
   parameter logic [REGION_BITS-1:0]  SPI_BASE    = 'hc5,
   parameter logic [REGION_BITS-1:0]  SECRET_BASE = 'hc2,
   parameter logic [ADDR_W-1:0]       TRIG_ADDR   = 'he100_0000,
   parameter logic [ADDR_W-1:0]       ENTRY_ADDR  = 'h0000_0010
) (
   input  logic [ADDR_W-1:0] addr_i,
   output region_e           region_o,
   output logic              trig_hit_o,
   output logic              entry_hit_o
);

   localparam int unsigned TOP_LSB = ADDR_W - REGION_BITS;
   localparam logic [REGION_BITS-1:0] TRIG_BASE = TRIG_ADDR[ADDR_W-1:TOP_LSB];
   localparam logic [REGION_BITS-1:0] BASES [NUM_GUARDED] =
      '{ROM_BASE, FWRAM_BASE, SPI_BASE, SECRET_BASE, TRIG_BASE};

   logic [REGION_BITS-1:0] top_byte;
   logic [NUM_GUARDED-1:0] hit;

   assign top_byte = addr_i[ADDR_W-1:TOP_LSB];

   for (genvar g = 0; g < NUM_GUARDED; g++) begin : g_hit
      assign hit[g] = (top_byte == BASES[g]);
   end

   // Lowest table index wins if two bases were ever set equal.
   always_comb begin
      region_o = RG_OPEN;
      for (int i = NUM_GUARDED - 1; i >= 0; i--) begin
         if (hit[i]) region_o = region_e'(3'(i));
      end
   end

   assign trig_hit_o  = (addr_i == TRIG_ADDR);
   assign entry_hit_o = (addr_i == ENTRY_ADDR);

endmodule

// File: rtl/pa_mode_tracker.sv
module pa_mode_tracker
   import priv_access_pkg::*;
#(
   parameter int unsigned IRQ_W    = 32,
   parameter int unsigned TRIG_IRQ = 31
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_valid_i,
   input  logic             req_fetch_i,
   input  logic             store_full_i,
   input  region_e          region_i,
   input  logic             trig_hit_i,
   input  logic             entry_hit_i,
   input  logic             irq_return_i,
   output mode_e            mode_o,
   output logic             secret_en_o,
   output logic             entry_now_o,
   output logic [IRQ_W-1:0] irq_vec_o
);

   mode_e mode_q, mode_d;
   logic  secret_q;
   logic  pend_q;
   logic  fetch_v;
   logic  leave_rom;
   logic  trig_store;

   assign fetch_v     = req_valid_i & req_fetch_i;
   assign leave_rom   = (mode_q == MODE_FW) & fetch_v & (region_i != RG_ROM);
   assign entry_now_o = (mode_q == MODE_APP) & pend_q & fetch_v & entry_hit_i;
   assign trig_store  = req_valid_i & store_full_i & trig_hit_i;

   always_comb begin
      mode_d = mode_q;
      if (leave_rom)                                 mode_d = MODE_APP;
      else if (entry_now_o)                          mode_d = MODE_SYS;
      else if ((mode_q == MODE_SYS) && irq_return_i) mode_d = MODE_APP;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q   <= MODE_FW;
         secret_q <= 1'b1;
         pend_q   <= 1'b0;
      end else begin
         mode_q <= mode_d;
         if (leave_rom) secret_q <= 1'b0;
         if (trig_store)       pend_q <= 1'b1;
         else if (entry_now_o) pend_q <= 1'b0;
      end
   end

   assign mode_o      = mode_q;
   assign secret_en_o = secret_q;

   for (genvar b = 0; b < IRQ_W; b++) begin : g_irq
      if (b == TRIG_IRQ) begin : g_live
         assign irq_vec_o[b] = pend_q;
      end else begin : g_tied
         assign irq_vec_o[b] = 1'b0;
      end
   end

endmodule

// File: rtl/pa_access_gate.sv
module pa_access_gate
   import priv_access_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   input  logic              req_fetch_i,
   input  logic              req_write_i,
   input  region_e           region_i,
   input  mode_e             mode_i,
   input  logic              entry_now_i,
   input  logic              secret_en_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              grant_o,
   output logic              hidden_o,
   output logic              violation_o,
   output logic [DATA_W-1:0] rdata_o
);

   mode_e eff_mode;
   perm_t perm;
   logic  kind_ok;
   logic  viol_q;
   logic  hide_q;

   // The entry fetch is judged with system call rights.
   assign eff_mode = entry_now_i ? MODE_SYS : mode_i;

   always_comb begin
      perm = '{vis: 1'b1, rd: 1'b1, wr: 1'b1, ex: 1'b1};
      case (region_i)
         RG_ROM: begin
            perm.wr = 1'b0;
            perm.ex = (eff_mode != MODE_APP);
         end
         RG_FWRAM, RG_SPI: begin
            perm.vis = (eff_mode != MODE_APP);
            perm.rd  = perm.vis;
            perm.wr  = perm.vis;
            perm.ex  = 1'b0;
         end
         RG_SECRET: begin
            perm.vis = (eff_mode == MODE_FW) & secret_en_i;
            perm.rd  = perm.vis;
            perm.wr  = perm.vis;
            perm.ex  = 1'b0;
         end
         RG_TRIG: begin
            perm.rd = 1'b0;
            perm.wr = 1'b0;
            perm.ex = 1'b0;
         end
         default: ;
      endcase
   end

   always_comb begin
      if (req_fetch_i)      kind_ok = perm.ex;
      else if (req_write_i) kind_ok = perm.wr;
      else                  kind_ok = perm.rd;
   end

   assign grant_o  = req_valid_i & perm.vis & kind_ok;
   assign hidden_o = req_valid_i & ~perm.vis;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         viol_q <= 1'b0;
         hide_q <= 1'b0;
      end else begin
         viol_q <= req_valid_i & req_fetch_i & ~perm.ex;
         hide_q <= req_valid_i & ~perm.vis & ~req_write_i;
      end
   end

   assign violation_o = viol_q;
   assign rdata_o     = hide_q ? '0 : mem_rdata_i;

endmodule

// File: rtl/priv_access_ctrl.sv
module priv_access_ctrl
   import priv_access_pkg::*;
#(
   parameter int unsigned            ADDR_W      = 32,
   parameter int unsigned            DATA_W      = 32,
   parameter int unsigned            STRB_W      = DATA_W / 8,
   parameter int unsigned            IRQ_W       = 32,
   parameter int unsigned            TRIG_IRQ    = 31,
   parameter int unsigned            REGION_BITS = 8,
   parameter logic [REGION_BITS-1:0] ROM_BASE    = 'h00,
   parameter logic [REGION_BITS-1:0] FWRAM_BASE  = 'hd0,
   parameter logic [REGION_BITS-1:0] SPI_BASE    = 'hc5,
   parameter logic [REGION_BITS-1:0] SECRET_BASE = 'hc2,
   parameter logic [ADDR_W-1:0]      TRIG_ADDR   = 'he100_0000,
   parameter logic [ADDR_W-1:0]      ENTRY_ADDR  = 'h0000_0010
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [STRB_W-1:0] req_wstrb_i,
   input  logic              req_fetch_i,
   input  logic              irq_return_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic [1:0]        mode_o,
   output logic              grant_o,
   output logic              hidden_o,
   output logic              violation_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic [IRQ_W-1:0]  irq_vec_o,
   output logic              secret_en_o
);

   localparam int unsigned TOP_LSB = ADDR_W - REGION_BITS;

   // Elaboration-time parameter checks.
   if (REGION_BITS == 0 || REGION_BITS > ADDR_W) begin : g_bad_region_bits
      $error("REGION_BITS must lie in 1..ADDR_W");
   end
   if (TRIG_IRQ >= IRQ_W) begin : g_bad_trig_irq
      $error("TRIG_IRQ must index into the irq vector");
   end
   if (STRB_W * 8 != DATA_W) begin : g_bad_strb
      $error("STRB_W must cover DATA_W in bytes");
   end
   if (ENTRY_ADDR[ADDR_W-1:TOP_LSB] != ROM_BASE) begin : g_bad_entry
      $error("ENTRY_ADDR must lie in the ROM region");
   end

   region_e region;
   mode_e   mode;
   logic    trig_hit;
   logic    entry_hit;
   logic    entry_now;
   logic    secret_en;
   logic    is_write;
   logic    store_full;

   assign is_write   = ~req_fetch_i & (|req_wstrb_i);
   assign store_full = ~req_fetch_i & (&req_wstrb_i);

   pa_region_decode #(
      .ADDR_W      (ADDR_W),
      .REGION_BITS (REGION_BITS),
      .ROM_BASE    (ROM_BASE),
      .FWRAM_BASE  (FWRAM_BASE),
      .SPI_BASE    (SPI_BASE),
      .SECRET_BASE (SECRET_BASE),
      .TRIG_ADDR   (TRIG_ADDR),
      .ENTRY_ADDR  (ENTRY_ADDR)
   ) u_decode (
      .addr_i      (req_addr_i),
      .region_o    (region),
      .trig_hit_o  (trig_hit),
      .entry_hit_o (entry_hit)
   );

   pa_mode_tracker #(
      .IRQ_W    (IRQ_W),
      .TRIG_IRQ (TRIG_IRQ)
   ) u_mode (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_valid_i  (req_valid_i),
      .req_fetch_i  (req_fetch_i),
      .store_full_i (store_full),
      .region_i     (region),
      .trig_hit_i   (trig_hit),
      .entry_hit_i  (entry_hit),
      .irq_return_i (irq_return_i),
      .mode_o       (mode),
      .secret_en_o  (secret_en),
      .entry_now_o  (entry_now),
      .irq_vec_o    (irq_vec_o)
   );

   pa_access_gate #(
      .DATA_W (DATA_W)
   ) u_gate (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_valid_i (req_valid_i),
      .req_fetch_i (req_fetch_i),
      .req_write_i (is_write),
      .region_i    (region),
      .mode_i      (mode),
      .entry_now_i (entry_now),
      .secret_en_i (secret_en),
      .mem_rdata_i (mem_rdata_i),
      .grant_o     (grant_o),
      .hidden_o    (hidden_o),
      .violation_o (violation_o),
      .rdata_o     (rdata_o)
   );

   assign mode_o      = mode;
   assign secret_en_o = secret_en;

endmodule

// File: rtl/priv_access_chk.sv
module priv_access_chk #(
   parameter int unsigned            ADDR_W      = 32,
   parameter int unsigned            IRQ_W       = 32,
   parameter int unsigned            TRIG_IRQ    = 31,
   parameter int unsigned            REGION_BITS = 8,
   parameter logic [REGION_BITS-1:0] ROM_BASE    = 'h00,
   parameter logic [REGION_BITS-1:0] SECRET_BASE = 'hc2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              req_valid_i,
   input logic [ADDR_W-1:0] req_addr_i,
   input logic              req_fetch_i,
   input logic              irq_return_i,
   input logic [1:0]        mode_o,
   input logic              grant_o,
   input logic              hidden_o,
   input logic              violation_o,
   input logic [IRQ_W-1:0]  irq_vec_o,
   input logic              secret_en_o
);

   localparam int unsigned TOP_LSB = ADDR_W - REGION_BITS;
   localparam logic [IRQ_W-1:0] OTHER_IRQS = ~(IRQ_W'(1) << TRIG_IRQ);

   logic [REGION_BITS-1:0] top_byte;
   assign top_byte = req_addr_i[ADDR_W-1:TOP_LSB];

   // R13
   mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o != 2'b11);

   // R4
   irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_vec_o & OTHER_IRQS) == '0);

   // R10
   secret_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !secret_en_o |=> !secret_en_o);

   // R12
   viol_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      violation_o |-> $past(req_valid_i && req_fetch_i));

   // R11
   hidden_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hidden_o |-> !grant_o);

   // R8
   secret_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && top_byte == SECRET_BASE && mode_o != 2'b00) |-> !grant_o);

   // R6
   irq_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b10 && irq_return_i) |=> mode_o == 2'b01);

   // R3
   leave_rom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b00 && req_valid_i && req_fetch_i && top_byte != ROM_BASE)
      |=> (mode_o == 2'b01 && !secret_en_o));

endmodule

bind priv_access_ctrl priv_access_chk #(
   .ADDR_W      (ADDR_W),
   .IRQ_W       (IRQ_W),
   .TRIG_IRQ    (TRIG_IRQ),
   .REGION_BITS (REGION_BITS),
   .ROM_BASE    (ROM_BASE),
   .SECRET_BASE (SECRET_BASE)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_valid_i  (req_valid_i),
   .req_addr_i   (req_addr_i),
   .req_fetch_i  (req_fetch_i),
   .irq_return_i (irq_return_i),
   .mode_o       (mode_o),
   .grant_o      (grant_o),
   .hidden_o     (hidden_o),
   .violation_o  (violation_o),
   .irq_vec_o    (irq_vec_o),
   .secret_en_o  (secret_en_o)
);

// File: tb/priv_access_ctrl_bench.sv
module priv_access_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_wstrb = '0;
   logic        req_fetch = 1'b0;
   logic        irq_ret = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [1:0]  mode;
   logic        grant, hidden, violation, secret_en;
   logic [31:0] rdata, irq_vec;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   // Behavioural reference state
   int m_mode;
   bit m_sec, m_pend, m_viol, m_hidq;

   always #4 clk = ~clk;

   priv_access_ctrl u_priv_access_ctrl (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .req_valid_i  (req_valid),
      .req_addr_i   (req_addr),
      .req_wstrb_i  (req_wstrb),
      .req_fetch_i  (req_fetch),
      .irq_return_i (irq_ret),
      .mem_rdata_i  (mem_rdata),
      .mode_o       (mode),
      .grant_o      (grant),
      .hidden_o     (hidden),
      .violation_o  (violation),
      .rdata_o      (rdata),
      .irq_vec_o    (irq_vec),
      .secret_en_o  (secret_en)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic int region_of(input logic [31:0] a);
      case (a[31:24])
         8'h00:   return 0;   // ROM
         8'hd0:   return 1;   // firmware RAM
         8'hc5:   return 2;   // SPI
         8'hc2:   return 3;   // secret store
         8'he1:   return 4;   // trigger window
         default: return 5;   // open
      endcase
   endfunction

   task automatic model_reset();
      m_mode = 0; m_sec = 1'b1; m_pend = 1'b0; m_viol = 1'b0; m_hidq = 1'b0;
   endtask

   task automatic step(input bit v, input logic [31:0] a, input logic [3:0] s,
                       input bit f, input bit r, input string tag);
      int  rg, eff;
      bit  wr, full, entry, vis, prd, pwr, pex, ok;
      @(negedge clk);
      req_valid = v; req_addr = a; req_wstrb = s; req_fetch = f; irq_ret = r;
      mem_rdata = 32'hC0DE_0000 ^ cyc;
      cyc++;
      #2;
      rg    = region_of(a);
      wr    = !f && (s != 4'h0);
      full  = !f && (s == 4'hF);
      entry = v && f && m_mode == 1 && m_pend && a == 32'h0000_0010;
      eff   = entry ? 2 : m_mode;
      vis = 1; prd = 1; pwr = 1; pex = 1;
      case (rg)
         0: begin pwr = 0; pex = (eff != 1); end
         1, 2: begin vis = (eff != 1); prd = vis; pwr = vis; pex = 0; end
         3: begin vis = (eff == 0) && m_sec; prd = vis; pwr = vis; pex = 0; end
         4: begin prd = 0; pwr = 0; pex = 0; end
         default: ;
      endcase
      ok = f ? pex : (wr ? pwr : prd);
      chk(tag, "grant", 32'(grant), 32'(v && vis && ok));
      chk(tag, "hidden", 32'(hidden), 32'(v && !vis));
      chk(tag, "mode", 32'(mode), 32'(m_mode));
      chk(tag, "secret_en", 32'(secret_en), 32'(m_sec));
      chk(tag, "irq_vec", irq_vec, {m_pend, 31'b0});
      chk(tag, "violation", 32'(violation), 32'(m_viol));
      chk(tag, "rdata", rdata, m_hidq ? 32'h0 : mem_rdata);
      chk("R13", "mode legal", 32'(mode == 2'b11), 32'h0);
      @(posedge clk);
      m_viol = v && f && !pex;
      m_hidq = v && !vis && !wr;
      if (v && wr && full && a == 32'he100_0000) m_pend = 1'b1;
      else if (entry)                            m_pend = 1'b0;
      if (m_mode == 0 && v && f && rg != 0) begin
         m_mode = 1; m_sec = 1'b0;
      end else if (entry) begin
         m_mode = 2;
      end else if (m_mode == 2 && r) begin
         m_mode = 1;
      end
   endtask

   task automatic idle(input string tag);
      step(1'b0, 32'h0, 4'h0, 1'b0, 1'b0, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_valid = 1'b0; req_wstrb = '0; req_fetch = 1'b0; irq_ret = 1'b0;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      model_reset();
      do_reset();
      idle("R1"); idle("R1");
      // Firmware mode rights
      step(1, 32'h0000_0100, 4'h0, 1, 0, "R7");
      step(1, 32'h0000_0200, 4'h0, 0, 0, "R7");
      step(1, 32'h0000_0004, 4'hF, 0, 0, "R7");
      step(1, 32'hd000_0010, 4'hF, 0, 0, "R7");
      step(1, 32'hc500_0000, 4'h0, 0, 0, "R7");
      step(1, 32'hc200_0004, 4'h0, 0, 0, "R7");
      step(1, 32'hd000_0020, 4'h0, 1, 0, "R12");
      idle("R12");
      step(1, 32'hc300_0000, 4'hF, 0, 0, "R2");
      step(1, 32'h0000_0010, 4'h0, 1, 0, "R5");
      // Leave ROM
      step(1, 32'h4000_0000, 4'h0, 1, 0, "R3");
      idle("R10");
      // Application mode rights
      step(1, 32'h0000_0300, 4'h0, 0, 0, "R9");
      step(1, 32'h0000_0300, 4'h0, 1, 0, "R9");
      step(1, 32'hd000_0000, 4'h0, 0, 0, "R11");
      idle("R11");
      step(1, 32'hc500_0008, 4'hF, 0, 0, "R9");
      step(1, 32'hc200_0000, 4'h0, 0, 0, "R9");
      step(1, 32'h0000_0010, 4'h0, 1, 0, "R12");
      step(1, 32'h4000_1000, 4'h0, 1, 0, "R2");
      step(0, 32'h0, 4'h0, 0, 1, "R6");
      // Trigger stores
      step(1, 32'he100_0000, 4'h3, 0, 0, "R4");
      step(1, 32'he100_0004, 4'hF, 0, 0, "R4");
      step(1, 32'he100_0000, 4'h0, 0, 0, "R4");
      step(1, 32'he100_0000, 4'hF, 0, 0, "R4");
      idle("R4");
      step(1, 32'h0000_0010, 4'h0, 1, 0, "R5");
      idle("R5");
      // System call mode rights
      step(1, 32'h0000_0014, 4'h0, 1, 0, "R8");
      step(1, 32'hd000_0100, 4'hF, 0, 0, "R8");
      step(1, 32'hc500_0000, 4'hF, 0, 0, "R8");
      step(1, 32'hc200_0000, 4'h0, 0, 0, "R8");
      step(1, 32'hc200_0000, 4'hF, 0, 0, "R8");
      step(1, 32'he100_0000, 4'hF, 0, 0, "R4");
      step(1, 32'h0000_0010, 4'h0, 1, 0, "R5");
      step(0, 32'h0, 4'h0, 0, 1, "R6");
      step(1, 32'hd000_0000, 4'hF, 0, 0, "R9");
      step(1, 32'h0000_0010, 4'h0, 1, 0, "R5");
      step(0, 32'h0, 4'h0, 0, 1, "R6");
      idle("R10");
      // Reset mid-run restores firmware rights
      do_reset();
      idle("R1");
      step(1, 32'hc200_0000, 4'h0, 0, 0, "R7");
      step(1, 32'hd000_0040, 4'h0, 1, 0, "R12");
      step(1, 32'h0000_0040, 4'h0, 1, 0, "R7");
      idle("R12");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule